// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sequences conversions on an external analog-to-digital converter over a small handshake. The converter takes a channel select and a one-cycle start strobe. Later it returns a one-cycle done strobe, a 12-bit sample and an error bit. The control inputs are register-style. An enable gates all activity. A one-cycle request starts a single conversion, and a held level requests continuous conversions. A channel-select value can be loaded while the block is idle. A channel mask picks which inputs a continuous or repeated sequence visits.

After each conversion completes, the block stores the sample and updates two error flags: one for the latest conversion and one that holds any past error. When the mask is nonzero, it moves the channel select to the next enabled input. In continuous mode, a fixed-point divisor sets the idle gap between one completion and the next start. The divisor has a 16-bit whole part and an 8-bit fraction. A running fraction accumulator adds one extra cycle to a gap each time it carries, so the average gap equals the divisor exactly.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, conv_start, last_err and sticky_err are 0, result is 0 and conv_sel is 0. ready then equals enable.
- R2: A one-cycle start_once while ready produces exactly one conv_start pulse, with conv_sel equal to the loaded channel. No further start follows once that conversion completes.
- R3: start_once is ignored while enable is low, and also while a conversion or pacing gap is under way: no extra conv_start results.
- R4: ready is 1 exactly when enable is 1 and the block is idle. It is 0 while a conversion is outstanding.
- R5: While start_many and enable are high, conversions repeat. If start_many is cleared, the conversion in flight completes, no new start follows and ready returns to 1. This holds whether start_many is cleared during a conversion or during a pacing gap.
- R6: On the done strobe, result takes conv_result one cycle later. At all other times it holds its value.
- R7: last_err takes conv_err of each completed conversion, so a good conversion clears it.
- R8: sticky_err is set by any conversion with conv_err=1. It stays set until sticky_clr is pulsed; a set in the same cycle takes priority over the clear.
- R9: With a nonzero rr_mask (bit i enables channel i, for channels 0 to 4), each completion moves conv_sel to the next higher enabled channel, wrapping to the lowest enabled one. If the current channel is not enabled, conv_sel moves to the lowest enabled channel.
- R10: With rr_mask zero, completions leave conv_sel unchanged. sel_wr loads sel_in only while idle and is ignored otherwise.
- R11: With div_int and div_frac both zero, the next conv_start of a continuous run comes in the cycle right after the done strobe, with no gap cycles.
- R12: In a continuous run, each gap is div_int cycles plus one extra cycle whenever an 8-bit accumulator, cleared while idle, carries after div_frac is added to it at a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable |
| start_once | input | 1 | One-cycle single-conversion request |
| start_many | input | 1 | Continuous-conversion request level |
| sel_in | input | 3 | Channel value to load |
| sel_wr | input | 1 | Load strobe for sel_in |
| rr_mask | input | 5 | Channel enable mask for sequencing |
| div_int | input | 16 | Whole part of pacing divisor |
| div_frac | input | 8 | Fraction part of pacing divisor (1/256 units) |
| sticky_clr | input | 1 | Clear strobe for sticky_err |
| conv_done | input | 1 | Converter done strobe |
| conv_result | input | 12 | Converter sample |
| conv_err | input | 1 | Converter error bit |
| conv_sel | output | 3 | Channel select to the converter |
| conv_start | output | 1 | Start strobe to the converter |
| ready | output | 1 | Idle and enabled |
| last_err | output | 1 | Error of latest conversion |
| sticky_err | output | 1 | Any error since last clear |
| result | output | 12 | Latest sample |

## Verification
The hardest state to reach from the ports is an accumulator carry that lands on a particular gap in a continuous run. Such a carry depends on how many completions have gone by since the block was last idle. The bench holds continuous runs of several conversions over a grid of whole and fractional divisor values. It predicts each gap with its own running-sum arithmetic and measures every gap in cycles. The round-robin move is swept over all 32 masks and all 8 starting channels.

// File: rtl/adc_seq_pkg.sv
// Package: shared types for the ADC conversion sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_rr_pick.sv
// Module: adc_rr_pick
// Picks the channel that follows cur_sel in chan_mask: the next higher
// enabled channel, else the lowest enabled one. If cur_sel is not enabled,
// it picks the lowest enabled channel. A zero mask keeps cur_sel.
// Assumes: MASK_W <= 2**SEL_W. Purely combinational.
module adc_rr_pick #(
    parameter int SEL_W  = 3,
    parameter int MASK_W = 5
) (
    input  logic [SEL_W-1:0]  cur_sel,
    input  logic [MASK_W-1:0] chan_mask,
    output logic [SEL_W-1:0]  next_sel
);
    logic [SEL_W-1:0] low_sel;
    logic [SEL_W-1:0] high_sel;
    logic             have_high;
    logic             cur_in;

    // Scan the mask from the top down so the lowest matching index wins.
    always_comb begin
        low_sel   = '0;
        high_sel  = '0;
        have_high = 1'b0;
        cur_in    = 1'b0;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            if (chan_mask[i]) begin
                low_sel = SEL_W'(i);
            end
            if (chan_mask[i] && (SEL_W'(i) > cur_sel)) begin
                high_sel  = SEL_W'(i);
                have_high = 1'b1;
            end
            if (chan_mask[i] && (SEL_W'(i) == cur_sel)) begin
                cur_in = 1'b1;
            end
        end
    end

    // Choose between holding, stepping up and wrapping.
    always_comb begin
        if (chan_mask == '0) begin
            next_sel = cur_sel;
        end else if (cur_in && have_high) begin
            next_sel = high_sel;
        end else begin
            next_sel = low_sel;
        end
    end

    // The chosen channel must be one the mask enables.
    always_comb begin
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < MASK_W; i++) begin
            if (chan_mask[i] && (next_sel == SEL_W'(i))) begin
                hit = 1'b1;
            end
        end
        AST_RR_IN_MASK: assert (chan_mask == '0 || hit); // R9
    end
endmodule

// File: rtl/adc_pace_div.sv
// Module: adc_pace_div
// Gap timer for continuous runs. On load it adds div_frac to an 8-bit
// accumulator and loads a countdown of div_int plus the carry. fire marks
// the last gap cycle. gap_zero shows that the gap a load would give now is
// zero. clr empties both the accumulator and the countdown.
// Assumes: clr and load never coincide (the caller's state keeps them apart).
module adc_pace_div #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              gap_zero,
    output logic              fire
);
    localparam int CNT_W = INT_W + 1;

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic [CNT_W-1:0]  gap_len;
    logic [CNT_W-1:0]  cnt_q;

    assign acc_sum  = {1'b0, acc_q} + {1'b0, div_frac};
    assign gap_len  = {1'b0, div_int} + CNT_W'(acc_sum[FRAC_W]);
    assign gap_zero = (gap_len == '0);
    assign fire     = (cnt_q == CNT_W'(1));

    // Accumulator and countdown update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            acc_q <= acc_sum[FRAC_W-1:0];
            cnt_q <= gap_len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    AST_CNT_DECR: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !clr && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R12
endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: adc_seq_ctrl (top)
// Sequences conversions on an external converter: single and continuous
// starts, channel stepping through a mask, fractional gap pacing, capture
// of the sample and the error flags.
// Assumes: conv_done is a one-cycle strobe that arrives only after
// conv_start. A done outside a conversion is ignored.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int MASK_W = 5,
    parameter int RES_W  = 12,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start_once,
    input  logic              start_many,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              sel_wr,
    input  logic [MASK_W-1:0] rr_mask,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              sticky_clr,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              conv_err,
    output logic [SEL_W-1:0]  conv_sel,
    output logic              conv_start,
    output logic              ready,
    output logic              last_err,
    output logic              sticky_err,
    output logic [RES_W-1:0]  result
);
    seq_state_t       state_q;
    logic             start_q;
    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] sel_next;
    logic             run_ok;
    logic             finish;
    logic             div_load;
    logic             div_clr;
    logic             gap_zero;
    logic             gap_fire;

    assign run_ok   = enable && start_many;
    assign finish   = (state_q == ST_CONV) && conv_done;
    assign div_load = finish && run_ok;
    assign div_clr  = (state_q == ST_IDLE) || ((state_q == ST_WAIT) && !run_ok);

    assign conv_sel   = sel_q;
    assign conv_start = start_q;
    assign ready      = enable && (state_q == ST_IDLE);

    adc_rr_pick #(.SEL_W(SEL_W), .MASK_W(MASK_W)) rr_i (
        .cur_sel   (sel_q),
        .chan_mask (rr_mask),
        .next_sel  (sel_next)
    );

    adc_pace_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) pace_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (div_clr),
        .load     (div_load),
        .div_int  (div_int),
        .div_frac (div_frac),
        .gap_zero (gap_zero),
        .fire     (gap_fire)
    );

    // Sequencer state and the one-cycle start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (enable && (start_once || start_many)) begin
                        state_q <= ST_CONV;
                        start_q <= 1'b1;
                    end
                end
                ST_CONV: begin
                    if (conv_done) begin
                        if (!run_ok) begin
                            state_q <= ST_IDLE;
                        end else if (gap_zero) begin
                            start_q <= 1'b1;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!run_ok) begin
                        state_q <= ST_IDLE;
                    end else if (gap_fire) begin
                        state_q <= ST_CONV;
                        start_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Channel select: load while idle, step through the mask on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if ((state_q == ST_IDLE) && sel_wr) begin
            sel_q <= sel_in;
        end else if (finish) begin
            sel_q <= sel_next;
        end
    end

    // Sample and latest-error capture on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            last_err <= 1'b0;
        end else if (finish) begin
            result   <= conv_result;
            last_err <= conv_err;
        end
    end

    // Sticky error: a set takes priority over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_err <= 1'b0;
        end else if (finish && conv_err) begin
            sticky_err <= 1'b1;
        end else if (sticky_clr) begin
            sticky_err <= 1'b0;
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !conv_done) |=> !conv_start); // R2
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(enable)); // R3
    AST_NOT_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !ready); // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(result)); // R6
    AST_ERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && conv_err) |=> (last_err && sticky_err)); // R7
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_err && !sticky_clr) |=> sticky_err); // R8
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable, start_once, start_many, sel_wr, sticky_clr;
    logic [2:0]  sel_in;
    logic [4:0]  rr_mask;
    logic [15:0] div_int;
    logic [7:0]  div_frac;
    logic        conv_done, conv_err;
    logic [11:0] conv_result;
    logic [2:0]  conv_sel;
    logic        conv_start, ready, last_err, sticky_err;
    logic [11:0] result;

    int checks = 0;
    int errors = 0;
    int rcount = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_once(start_once),
        .start_many(start_many), .sel_in(sel_in), .sel_wr(sel_wr),
        .rr_mask(rr_mask), .div_int(div_int), .div_frac(div_frac),
        .sticky_clr(sticky_clr), .conv_done(conv_done),
        .conv_result(conv_result), .conv_err(conv_err),
        .conv_sel(conv_sel), .conv_start(conv_start), .ready(ready),
        .last_err(last_err), .sticky_err(sticky_err), .result(result)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int rr_model(input int cur, input int mask);
        if (mask == 0) return cur;
        if (cur < 5 && mask[cur]) begin
            for (int i = cur + 1; i < 5; i++) if (mask[i]) return i;
        end
        for (int i = 0; i < 5; i++) if (mask[i]) return i;
        return cur;
    endfunction

    // Wait for a start, answer it as the converter, check capture.
    task automatic do_conv(input int exp_sel, input bit err, input bit last,
                           input bit chk_gap, input int exp_gap, input bit poke,
                           input string tag);
        int g = 0;
        int res;
        while (!conv_start && g < 300) begin
            @(negedge clk);
            g++;
        end
        if (chk_gap) chk({tag, " gap"}, g, exp_gap);
        chk("R2 conv_sel at start", conv_sel, exp_sel);
        chk("R4 ready while converting", ready, 0);
        @(negedge clk);
        if (poke) begin
            start_once = 1'b1; sel_in = 3'd6; sel_wr = 1'b1;
        end
        @(negedge clk);
        start_once = 1'b0; sel_wr = 1'b0;
        res = (rcount * 1237 + 5) % 4096;
        rcount++;
        conv_result = 12'(res);
        conv_err = err;
        if (last) start_many = 1'b0;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        conv_err = 1'b0;
        chk("R6 result capture", result, res);
        chk("R7 last_err", last_err, err);
    endtask

    task automatic quiet(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (conv_start) seen++;
        end
        chk(tag, seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; start_once = 1'b0; start_many = 1'b0;
        sel_wr = 1'b0; sticky_clr = 1'b0; sel_in = '0; rr_mask = '0;
        div_int = '0; div_frac = '0; conv_done = 1'b0; conv_err = 1'b0;
        conv_result = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 conv_start", conv_start, 0);
        chk("R1 ready disabled", ready, 0);
        chk("R1 result", result, 0);
        chk("R1 last_err", last_err, 0);
        chk("R1 sticky_err", sticky_err, 0);
        chk("R1 conv_sel", conv_sel, 0);

        // R3: start while disabled is ignored
        start_once = 1'b1;
        @(negedge clk);
        start_once = 1'b0;
        quiet(5, "R3 start ignored when disabled");
        enable = 1'b1;
        @(negedge clk);
        chk("R4 ready when enabled idle", ready, 1);

        // R9/R10/R2: sweep every mask and starting channel
        for (int m = 0; m < 32; m++) begin
            for (int s = 0; s < 8; s++) begin
                sel_in = 3'(s); sel_wr = 1'b1;
                @(negedge clk);
                sel_wr = 1'b0;
                rr_mask = 5'(m);
                start_once = 1'b1;
                @(negedge clk);
                start_once = 1'b0;
                do_conv(s, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R2");
                chk(m == 0 ? "R10 sel held, zero mask" : "R9 round-robin step",
                    conv_sel, rr_model(s, m));
                quiet(2, "R2 exactly one start");
                chk("R4 ready after single", ready, 1);
            end
        end

        // R3/R10: start and select load during a conversion are ignored
        rr_mask = '0;
        sel_in = 3'd1; sel_wr = 1'b1;
        @(negedge clk);
        sel_wr = 1'b0;
        start_once = 1'b1;
        @(negedge clk);
        start_once = 1'b0;
        do_conv(1, 1'b0, 1'b0, 1'b0, 0, 1'b1, "R3");
        chk("R10 sel_wr ignored while busy", conv_sel, 1);
        quiet(4, "R3 start ignored while busy");

        // R7/R8: error flags
        start_once = 1'b1;
        @(negedge clk);
        start_once = 1'b0;
        do_conv(1, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R7");
        chk("R8 sticky set", sticky_err, 1);
        start_once = 1'b1;
        @(negedge clk);
        start_once = 1'b0;
        do_conv(1, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R7");
        chk("R8 sticky held after good conversion", sticky_err, 1);
        sticky_clr = 1'b1;
        @(negedge clk);
        sticky_clr = 1'b0;
        chk("R8 sticky cleared", sticky_err, 0);

        // R5/R11/R12: continuous runs over a divisor grid
        rr_mask = 5'b10110;
        for (int ii = 0; ii < 3; ii++) begin
            for (int fi = 0; fi < 5; fi++) begin
                int iv;
                int fv;
                int acc;
                int egap;
                int smod;
                iv = (ii == 2) ? 3 : ii;
                fv = (fi == 0) ? 0 : (fi == 1) ? 1 : (fi == 2) ? 64 : (fi == 3) ? 100 : 255;
                div_int = 16'(iv); div_frac = 8'(fv);
                sel_in = 3'd1; sel_wr = 1'b1;
                @(negedge clk);
                sel_wr = 1'b0;
                acc = 0; egap = 0; smod = 1;
                start_many = 1'b1;
                @(negedge clk);
                for (int k = 0; k < 6; k++) begin
                    do_conv(smod, 1'b0, k == 5, k > 0, egap, 1'b0,
                            (iv == 0 && fv == 0) ? "R11" : "R12");
                    acc = acc + fv;
                    egap = iv + acc / 256;
                    acc = acc % 256;
                    smod = rr_model(smod, 22);
                end
                quiet(6, "R5 run stops after in-flight conversion");
                chk("R5 ready after run", ready, 1);
            end
        end

        // R5: clear the run during a pacing gap
        div_int = 16'd5; div_frac = '0;
        start_many = 1'b1;
        @(negedge clk);
        do_conv(conv_sel, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R5");
        @(negedge clk);
        @(negedge clk);
        start_many = 1'b0;
        quiet(10, "R5 stop during gap");
        chk("R5 ready after gap stop", ready, 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule